// File: doc/BRIEF.md
# Load Miss Merge File

This block tracks data-cache load misses between a first-level data cache and the second-level cache. Every miss names a byte address, an access size and a destination register. The first miss to a 32-byte block claims one of six tracking entries and queues exactly one refill request toward the second level. Later misses to a block that already has an entry join it: they take a slot from a shared pool of 21 load slots, and they issue no further request.

Refill data comes back as two 16-byte beats, each tagged with the entry number and the beat index. As soon as a beat is held, every load whose bytes lie in that beat becomes eligible for a register write. Up to two register writes leave per cycle, on two fill lanes. An entry is released once both beats have arrived and all of its loads have been written back.

Top module: `load_miss_file`

## Requirements
- R1: The block address is the miss address with its low 5 bits dropped. Each valid entry tracks a different block, and there are at most 6 entries.
- R2: A miss whose block matches a valid entry is accepted into that entry. It does not claim a new entry and issues no new refill request.
- R3: Loads to the same block merge whatever their order and byte offsets. Every merged load receives its own register write.
- R4: At most 21 loads are outstanding. miss_ready is low when all load slots are taken. It is also low when the block matches no entry and all 6 entries are in use. While miss_ready is low, nothing is accepted.
- R5: Each claimed entry makes one request, carrying the block address and the entry number as tag. Requests leave in the order the entries were claimed. While req_ready is low, req_valid, req_blk and req_tag stay unchanged.
- R6: rsp_beat 0 carries block bytes 0-15 and rsp_beat 1 carries bytes 16-31; byte k sits at rsp_data[8k+7:8k] of its beat. A load is written back only after the beat holding its bytes has been captured, in the cycle after that capture at the earliest. Loads in beat 0 do not wait for beat 1.
- R7: At most two register writes occur per cycle. Lane 1 is used only when lane 0 is also used.
- R8: miss_size codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bytes. Loads are naturally aligned. The write data holds the loaded bytes little-endian in its low bits, zero-extended to 64 bits.
- R9: An entry stays held until both beats have arrived and every merged load has been written back. After that it is free, and a later miss to the same block claims a new entry and makes a new request.
- R10: A miss that arrives in the same cycle as the final refill beat of its block merges into that entry. It is written back from that refill data.
- R11: After reset, miss_ready is high and req_valid and fill_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | A load miss is presented |
| miss_ready | output | 1 | The presented miss is accepted this cycle |
| miss_addr | input | 40 | Byte address of the missing load |
| miss_size | input | 2 | Access size code |
| miss_dst | input | 6 | Destination register |
| req_valid | output | 1 | Refill request presented |
| req_ready | input | 1 | Second level takes the request |
| req_blk | output | 35 | Block address to refill |
| req_tag | output | 3 | Entry number of the request |
| rsp_valid | input | 1 | A refill beat is delivered |
| rsp_tag | input | 3 | Entry number the beat belongs to |
| rsp_beat | input | 1 | Which half of the block |
| rsp_data | input | 128 | Beat data |
| fill_valid | output | 2 | Register write per lane |
| fill_dst | output | 12 | Destination register per lane, lane l at [6l+5:6l] |
| fill_data | output | 128 | Write data per lane, lane l at [64l+63:64l] |

## Verification
The hardest case to reach from the ports is a miss that lands on an entry in the very cycle its last refill beat is captured. The entry must be otherwise idle, with every earlier load already written back, so that a wrong release decision would drop it. The bench first completes a single beat-0 load and waits for its write, then drives the beat-1 response and a new beat-1 miss to the same block in one cycle. It then checks that no second request appears and that the new load gets the refilled bytes. Slot and entry exhaustion are reached by holding req_ready low, or by filling the slot pool with 21 single-byte loads before any refill arrives.

// File: rtl/lmf_pkg.sv
// Shared definitions for the load miss file.
// Assumes fill data is at most 64 bits wide.
package lmf_pkg;

    typedef enum logic [1:0] {
        LD_BYTE  = 2'd0,
        LD_HALF  = 2'd1,
        LD_WORD  = 2'd2,
        LD_DWORD = 2'd3
    } ld_size_e;

    // Byte-lane mask for a load of the given size code.
    function automatic logic [63:0] size_mask(input logic [1:0] sz);
        logic [63:0] m;
        case (ld_size_e'(sz))
            LD_BYTE:  m = 64'h0000_0000_0000_00ff;
            LD_HALF:  m = 64'h0000_0000_0000_ffff;
            LD_WORD:  m = 64'h0000_0000_ffff_ffff;
            default:  m = 64'hffff_ffff_ffff_ffff;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/lmf_first_set.sv
// Lowest-index set-bit finder.
// Reports whether any bit is set and the index of the lowest one.
// Assumes IW is wide enough to hold W-1.
module lmf_first_set #(
    parameter int W  = 8,
    parameter int IW = 3
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);

    // Scan from the top so the lowest set bit wins.
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/lmf_blk_cam.sv
// Block-address match across all tracking entries.
// Compares one incoming block address with every valid entry.
// Assumes the owner never holds two valid entries for one block.
module lmf_blk_cam #(
    parameter int N_ENT = 6,
    parameter int BLK_W = 35,
    parameter int ENT_W = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_ENT-1:0]            ent_v,
    input  logic [N_ENT-1:0][BLK_W-1:0] ent_blk,
    input  logic [BLK_W-1:0]            look_blk,
    output logic                        hit,
    output logic [ENT_W-1:0]            hit_idx
);

    logic [N_ENT-1:0] hit_vec;

    // Per-entry equality against the looked-up block.
    for (genvar e = 0; e < N_ENT; e++) begin : g_cmp
        assign hit_vec[e] = ent_v[e] && (ent_blk[e] == look_blk);
    end

    lmf_first_set #(.W(N_ENT), .IW(ENT_W)) u_hit (
        .vec   (hit_vec),
        .found (hit),
        .idx   (hit_idx)
    );

    // R1: no block is ever tracked by two entries at once.
    p_one_entry_per_block_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

endmodule

// File: rtl/lmf_req_fifo.sv
// Allocation-order queue of entry numbers awaiting a refill request.
// Head is presented while the queue is non-empty.
// Assumes pop is only raised while out_valid is high.
module lmf_req_fifo #(
    parameter int DEPTH = 6,
    parameter int W     = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_val,
    input  logic         pop,
    output logic         out_valid,
    output logic [W-1:0] out_val
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_val;
    end

    assign out_valid = (cnt != '0);
    assign out_val   = mem[rd_ptr];

    // R5: a request is never queued into a full queue.
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (cnt < CW'(DEPTH)) || pop);

endmodule

// File: rtl/load_miss_file.sv
// Load miss file: tracks up to N_ENT outstanding L1 blocks, merges loads
// to the same block into a shared pool of N_SLOT load slots, queues one
// refill request per block, and writes back up to N_FILL loads per cycle.
// Assumes: loads are naturally aligned; refill beats carry a valid tag of
// a live entry; the register file accepts every write presented.
module load_miss_file #(
    parameter int N_ENT      = 6,
    parameter int N_SLOT     = 21,
    parameter int N_FILL     = 2,
    parameter int ADDR_W     = 40,
    parameter int REG_W      = 6,
    parameter int BLK_BYTES  = 32,
    parameter int BEAT_BYTES = 16,
    parameter int FILL_W     = 64,
    localparam int OFF_W     = $clog2(BLK_BYTES),
    localparam int BOFF_W    = $clog2(BEAT_BYTES),
    localparam int BI_W      = OFF_W - BOFF_W,
    localparam int N_BEAT    = BLK_BYTES / BEAT_BYTES,
    localparam int BEAT_W    = BEAT_BYTES * 8,
    localparam int BLK_W     = ADDR_W - OFF_W,
    localparam int ENT_W     = $clog2(N_ENT),
    localparam int SLOT_W    = $clog2(N_SLOT)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     miss_valid,
    output logic                     miss_ready,
    input  logic [ADDR_W-1:0]        miss_addr,
    input  logic [1:0]               miss_size,
    input  logic [REG_W-1:0]         miss_dst,
    output logic                     req_valid,
    input  logic                     req_ready,
    output logic [BLK_W-1:0]         req_blk,
    output logic [ENT_W-1:0]         req_tag,
    input  logic                     rsp_valid,
    input  logic [ENT_W-1:0]         rsp_tag,
    input  logic [BI_W-1:0]          rsp_beat,
    input  logic [BEAT_W-1:0]        rsp_data,
    output logic [N_FILL-1:0]        fill_valid,
    output logic [N_FILL*REG_W-1:0]  fill_dst,
    output logic [N_FILL*FILL_W-1:0] fill_data
);

    // Entry state.
    logic [N_ENT-1:0]                          ent_v;
    logic [N_ENT-1:0][BLK_W-1:0]               ent_blk;
    logic [N_ENT-1:0][N_BEAT-1:0]              ent_got;
    logic [N_ENT-1:0][N_BEAT-1:0][BEAT_W-1:0]  ent_data;
    logic [N_ENT-1:0]                          ent_busy;
    logic [N_ENT-1:0]                          ent_done;

    // Load slot state.
    logic [N_SLOT-1:0] slot_v;
    logic [ENT_W-1:0]  slot_ent [N_SLOT];
    logic [OFF_W-1:0]  slot_off [N_SLOT];
    logic [1:0]        slot_sz  [N_SLOT];
    logic [REG_W-1:0]  slot_dst [N_SLOT];
    logic [N_SLOT-1:0] slot_rdy;
    logic [N_SLOT-1:0] slot_clr;

    // Miss-side decode.
    logic [BLK_W-1:0]  miss_blk;
    logic [OFF_W-1:0]  miss_off;
    logic              hit, ent_free_found, slot_free_found;
    logic [ENT_W-1:0]  hit_idx, ent_free_idx, tgt_ent;
    logic [SLOT_W-1:0] slot_free_idx;
    logic              acc, alloc;

    // Fill lane selection.
    logic [N_SLOT-1:0] rem      [N_FILL+1];
    logic              pick_v   [N_FILL];
    logic [SLOT_W-1:0] pick_idx [N_FILL];

    // Request queue head.
    logic              q_valid;
    logic [ENT_W-1:0]  q_ent;

    assign miss_blk = miss_addr[ADDR_W-1:OFF_W];
    assign miss_off = miss_addr[OFF_W-1:0];

    lmf_blk_cam #(.N_ENT(N_ENT), .BLK_W(BLK_W), .ENT_W(ENT_W)) u_cam (
        .clk      (clk),
        .rst_n    (rst_n),
        .ent_v    (ent_v),
        .ent_blk  (ent_blk),
        .look_blk (miss_blk),
        .hit      (hit),
        .hit_idx  (hit_idx)
    );

    lmf_first_set #(.W(N_ENT), .IW(ENT_W)) u_ent_free (
        .vec   (~ent_v),
        .found (ent_free_found),
        .idx   (ent_free_idx)
    );

    lmf_first_set #(.W(N_SLOT), .IW(SLOT_W)) u_slot_free (
        .vec   (~slot_v),
        .found (slot_free_found),
        .idx   (slot_free_idx)
    );

    assign miss_ready = slot_free_found && (hit || ent_free_found);
    assign acc        = miss_valid && miss_ready;
    assign alloc      = acc && !hit;
    assign tgt_ent    = hit ? hit_idx : ent_free_idx;

    // A slot is ready once the beat holding its bytes has been captured.
    always_comb begin
        for (int s = 0; s < N_SLOT; s++) begin
            slot_rdy[s] = slot_v[s] &&
                          ent_got[slot_ent[s]][slot_off[s][OFF_W-1:BOFF_W]];
        end
    end

    assign rem[0] = slot_rdy;

    // One lane per register write: pick the lowest ready slot not yet taken.
    for (genvar l = 0; l < N_FILL; l++) begin : g_lane
        logic [ENT_W-1:0]  l_ent;
        logic [OFF_W-1:0]  l_off;
        logic [BEAT_W-1:0] l_beat;

        lmf_first_set #(.W(N_SLOT), .IW(SLOT_W)) u_pick (
            .vec   (rem[l]),
            .found (pick_v[l]),
            .idx   (pick_idx[l])
        );

        assign rem[l+1] = rem[l] &
                          ~((N_SLOT'(1) << pick_idx[l]) & {N_SLOT{pick_v[l]}});
        assign l_ent  = slot_ent[pick_idx[l]];
        assign l_off  = slot_off[pick_idx[l]];
        assign l_beat = ent_data[l_ent][l_off[OFF_W-1:BOFF_W]];

        assign fill_valid[l]                   = pick_v[l];
        assign fill_dst[l*REG_W +: REG_W]      = slot_dst[pick_idx[l]];
        assign fill_data[l*FILL_W +: FILL_W]   =
            FILL_W'(l_beat >> {l_off[BOFF_W-1:0], 3'b000}) &
            FILL_W'(lmf_pkg::size_mask(slot_sz[pick_idx[l]]));
    end

    // Slots written back this cycle.
    always_comb begin
        slot_clr = '0;
        for (int l = 0; l < N_FILL; l++) begin
            if (pick_v[l]) slot_clr[pick_idx[l]] = 1'b1;
        end
    end

    // An entry may retire when all beats are in and no load still needs it.
    always_comb begin
        for (int e = 0; e < N_ENT; e++) begin
            ent_busy[e] = acc && (tgt_ent == ENT_W'(e));
            for (int s = 0; s < N_SLOT; s++) begin
                if (slot_v[s] && !slot_clr[s] && (slot_ent[s] == ENT_W'(e)))
                    ent_busy[e] = 1'b1;
            end
            ent_done[e] = ent_v[e] && (&ent_got[e]) && !ent_busy[e];
        end
    end

    // Entry lifecycle: claim, beat capture, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_v   <= '0;
            ent_got <= '0;
            ent_blk <= '0;
        end else begin
            for (int e = 0; e < N_ENT; e++) begin
                if (ent_done[e]) ent_v[e] <= 1'b0;
                if (alloc && (ent_free_idx == ENT_W'(e))) begin
                    ent_v[e]   <= 1'b1;
                    ent_blk[e] <= miss_blk;
                    ent_got[e] <= '0;
                end
                if (rsp_valid && ent_v[e] && (rsp_tag == ENT_W'(e)))
                    ent_got[e][rsp_beat] <= 1'b1;
            end
        end
    end

    // Refill data capture; contents need no reset.
    always_ff @(posedge clk) begin
        if (rsp_valid && ent_v[rsp_tag])
            ent_data[rsp_tag][rsp_beat] <= rsp_data;
    end

    // Slot lifecycle: claim on accept, release on write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_v <= '0;
        end else begin
            for (int s = 0; s < N_SLOT; s++) begin
                if (slot_clr[s]) slot_v[s] <= 1'b0;
                if (acc && (slot_free_idx == SLOT_W'(s))) slot_v[s] <= 1'b1;
            end
        end
    end

    // Slot payload; meaningful only while the slot is valid.
    always_ff @(posedge clk) begin
        for (int s = 0; s < N_SLOT; s++) begin
            if (acc && (slot_free_idx == SLOT_W'(s))) begin
                slot_ent[s] <= tgt_ent;
                slot_off[s] <= miss_off;
                slot_sz[s]  <= miss_size;
                slot_dst[s] <= miss_dst;
            end
        end
    end

    lmf_req_fifo #(.DEPTH(N_ENT), .W(ENT_W)) u_reqq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (alloc),
        .push_val  (ent_free_idx),
        .pop       (req_valid && req_ready),
        .out_valid (q_valid),
        .out_val   (q_ent)
    );

    assign req_valid = q_valid;
    assign req_tag   = q_ent;
    assign req_blk   = ent_blk[q_ent];

    // R4: with a free slot and a free entry, a miss is never refused.
    p_ready_when_room_r4: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid && ($countones(slot_v) < N_SLOT) &&
        ($countones(ent_v) < N_ENT) |-> miss_ready);

    // R5: a stalled request holds its contents.
    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_blk) && $stable(req_tag));

    // R9: no waiting load ever points at a released entry.
    for (genvar s = 0; s < N_SLOT; s++) begin : g_chk
        p_slot_owner_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
            slot_v[s] |-> ent_v[slot_ent[s]]);
    end

endmodule

// File: tb/sim_load_miss_file.sv
`timescale 1ns/1ps
// Directed bench for the load miss file: one task per scenario.
module sim_load_miss_file;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         miss_valid = 1'b0;
    logic         miss_ready;
    logic [39:0]  miss_addr = '0;
    logic [1:0]   miss_size = '0;
    logic [5:0]   miss_dst = '0;
    logic         req_valid;
    logic         req_ready = 1'b1;
    logic [34:0]  req_blk;
    logic [2:0]   req_tag;
    logic         rsp_valid = 1'b0;
    logic [2:0]   rsp_tag = '0;
    logic [0:0]   rsp_beat = '0;
    logic [127:0] rsp_data = '0;
    logic [1:0]   fill_valid;
    logic [11:0]  fill_dst;
    logic [127:0] fill_data;

    int n_chk = 0;
    int n_err = 0;
    int got_cnt [64];
    logic [63:0] got_val [64];
    logic [34:0] log_blk [64];
    logic [2:0]  log_tag [64];
    int req_n = 0;
    int max_fill = 0;
    int lane_err = 0;

    always #2.5 clk = ~clk;

    load_miss_file u0 (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_addr(miss_addr),
        .miss_size(miss_size), .miss_dst(miss_dst),
        .req_valid(req_valid), .req_ready(req_ready), .req_blk(req_blk), .req_tag(req_tag),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_beat(rsp_beat), .rsp_data(rsp_data),
        .fill_valid(fill_valid), .fill_dst(fill_dst), .fill_data(fill_data)
    );

    // Record writes and request handshakes away from the clock edge.
    always @(negedge clk) begin
        if (rst_n) begin
            int nf;
            nf = 0;
            for (int l = 0; l < 2; l++) begin
                if (fill_valid[l]) begin
                    got_cnt[fill_dst[l*6 +: 6]]++;
                    got_val[fill_dst[l*6 +: 6]] = fill_data[l*64 +: 64];
                    nf++;
                end
            end
            if (nf > max_fill) max_fill = nf;
            if (fill_valid[1] && !fill_valid[0]) lane_err++;
            if (req_valid && req_ready) begin
                log_blk[req_n] = req_blk;
                log_tag[req_n] = req_tag;
                req_n++;
            end
        end
    end

    function automatic logic [7:0] bv(input logic [34:0] blk, input int i);
        return 8'(blk[7:0] * 8'd5 + 8'(i * 11) + 8'd3);
    endfunction

    function automatic logic [127:0] beatd(input logic [34:0] blk, input int b);
        logic [127:0] v;
        for (int i = 0; i < 16; i++) v[8*i +: 8] = bv(blk, b * 16 + i);
        return v;
    endfunction

    function automatic logic [63:0] expf(input logic [34:0] blk, input int off, input int sz);
        logic [63:0] v;
        v = '0;
        for (int i = 0; i < (1 << sz); i++) v[8*i +: 8] = bv(blk, off + i);
        return v;
    endfunction

    function automatic logic [2:0] tag_of(input logic [34:0] blk);
        logic [2:0] t;
        t = '0;
        for (int i = 0; i < req_n; i++) if (log_blk[i] == blk) t = log_tag[i];
        return t;
    endfunction

    task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic clear_got();
        for (int i = 0; i < 64; i++) begin
            got_cnt[i] = 0;
            got_val[i] = '0;
        end
    endtask

    task automatic set_miss(input logic [34:0] blk, input int off, input int sz, input int dst);
        miss_valid = 1'b1;
        miss_addr  = {blk, 5'(off)};
        miss_size  = 2'(sz);
        miss_dst   = 6'(dst);
    endtask

    task automatic miss(input logic [34:0] blk, input int off, input int sz, input int dst);
        set_miss(blk, off, sz, dst);
        @(negedge clk);
        while (!miss_ready) @(negedge clk);
        @(posedge clk);
        #1;
        miss_valid = 1'b0;
    endtask

    task automatic beat(input logic [2:0] tag, input int b, input logic [34:0] blk);
        rsp_valid = 1'b1;
        rsp_tag   = tag;
        rsp_beat  = 1'(b);
        rsp_data  = beatd(blk, b);
        @(posedge clk);
        #1;
        rsp_valid = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R11 miss_ready", 64'(miss_ready), 64'd1);
        chk("R11 req_valid", 64'(req_valid), 64'd0);
        chk("R11 fill_valid", 64'(fill_valid), 64'd0);
        @(posedge clk);
        #1;
    endtask

    task automatic t_single();
        logic [34:0] b;
        int r0;
        b = 35'h0_1234_5601;
        clear_got();
        r0 = req_n;
        miss(b, 4, 2, 1);
        idle(2);
        chk("R5 one request", 64'(req_n - r0), 64'd1);
        chk("R1 request block", 64'(log_blk[r0]), 64'(b));
        beat(tag_of(b), 0, b);
        idle(1);
        chk("R8 word fill", got_val[1], expf(b, 4, 2));
        chk("R6 one fill", 64'(got_cnt[1]), 64'd1);
        beat(tag_of(b), 1, b);
        idle(2);
    endtask

    task automatic t_merge();
        logic [34:0] b;
        logic [2:0] t;
        int r0;
        b = 35'h0_0abc_de12;
        clear_got();
        max_fill = 0;
        r0 = req_n;
        miss(b, 24, 3, 2);
        miss(b, 0, 0, 3);
        miss(b, 18, 1, 4);
        miss(b, 8, 3, 5);
        miss(b, 2, 1, 6);
        idle(2);
        chk("R2 merged one request", 64'(req_n - r0), 64'd1);
        t = tag_of(b);
        beat(t, 0, b);
        idle(3);
        chk("R6 beat0 reg3", got_val[3], expf(b, 0, 0));
        chk("R6 beat0 reg5", got_val[5], expf(b, 8, 3));
        chk("R6 beat0 reg6", got_val[6], expf(b, 2, 1));
        chk("R6 beat1 loads wait", 64'(got_cnt[2] + got_cnt[4]), 64'd0);
        beat(t, 1, b);
        idle(3);
        chk("R3 reg2", got_val[2], expf(b, 24, 3));
        chk("R8 half at 18", got_val[4], expf(b, 18, 1));
        chk("R3 each once", 64'(got_cnt[2] + got_cnt[3] + got_cnt[4] + got_cnt[5] + got_cnt[6]), 64'd5);
        chk("R7 two writes in a cycle", 64'(max_fill), 64'd2);
        chk("R7 lane order", 64'(lane_err), 64'd0);
    endtask

    task automatic t_capacity();
        logic [34:0] c [7];
        int r0, ok;
        clear_got();
        for (int k = 0; k < 7; k++) c[k] = 35'h0_2000_0000 + 35'(k * 3);
        req_ready = 1'b0;
        r0 = req_n;
        for (int k = 0; k < 6; k++) miss(c[k], 0, 3, 10 + k);
        idle(2);
        chk("R5 head held valid", 64'(req_valid), 64'd1);
        chk("R5 head held block", 64'(req_blk), 64'(c[0]));
        set_miss(c[6], 0, 3, 17);
        @(negedge clk);
        chk("R4 no free entry", 64'(miss_ready), 64'd0);
        @(posedge clk);
        #1;
        set_miss(c[3], 16, 3, 16);
        @(negedge clk);
        chk("R2 merge while entries full", 64'(miss_ready), 64'd1);
        @(posedge clk);
        #1;
        miss_valid = 1'b0;
        req_ready  = 1'b1;
        idle(8);
        chk("R5 six requests", 64'(req_n - r0), 64'd6);
        ok = 0;
        for (int k = 0; k < 6; k++) if (log_blk[r0 + k] == c[k]) ok++;
        chk("R5 allocation order", 64'(ok), 64'd6);
        for (int k = 0; k < 6; k++) begin
            beat(tag_of(c[k]), 0, c[k]);
            beat(tag_of(c[k]), 1, c[k]);
        end
        idle(4);
        ok = 0;
        for (int k = 0; k < 6; k++) if (got_val[10 + k] == expf(c[k], 0, 3)) ok++;
        chk("R3 six blocks filled", 64'(ok), 64'd6);
        chk("R3 merged beat1 load", got_val[16], expf(c[3], 16, 3));
        r0 = req_n;
        miss(c[6], 8, 2, 17);
        idle(2);
        chk("R9 freed entry reused", 64'(req_n - r0), 64'd1);
        beat(tag_of(c[6]), 0, c[6]);
        beat(tag_of(c[6]), 1, c[6]);
        idle(3);
        chk("R9 reused entry fill", got_val[17], expf(c[6], 8, 2));
    endtask

    task automatic t_slots();
        logic [34:0] d [3];
        int offs [7];
        int r0, ok, dst;
        offs = '{0, 5, 9, 13, 16, 22, 31};
        clear_got();
        for (int k = 0; k < 3; k++) d[k] = 35'h0_3300_0040 + 35'(k * 17);
        r0 = req_n;
        for (int k = 0; k < 3; k++)
            for (int j = 0; j < 7; j++) miss(d[k], offs[j], 0, 20 + k * 7 + j);
        set_miss(d[0], 1, 0, 41);
        @(negedge clk);
        chk("R4 slot pool full", 64'(miss_ready), 64'd0);
        @(posedge clk);
        #1;
        miss_valid = 1'b0;
        idle(1);
        chk("R2 three requests", 64'(req_n - r0), 64'd3);
        for (int k = 0; k < 3; k++) begin
            beat(tag_of(d[k]), 1, d[k]);
            beat(tag_of(d[k]), 0, d[k]);
        end
        idle(8);
        ok = 0;
        for (int k = 0; k < 3; k++)
            for (int j = 0; j < 7; j++) begin
                dst = 20 + k * 7 + j;
                if (got_cnt[dst] == 1 && got_val[dst] == expf(d[k], offs[j], 0)) ok++;
            end
        chk("R3 all 21 loads", 64'(ok), 64'd21);
        chk("R4 refused load not filled", 64'(got_cnt[41]), 64'd0);
    endtask

    task automatic t_late_merge();
        logic [34:0] e;
        logic [2:0] t;
        int r0;
        e = 35'h0_4455_6677;
        clear_got();
        r0 = req_n;
        miss(e, 3, 0, 42);
        idle(2);
        t = tag_of(e);
        beat(t, 0, e);
        idle(2);
        chk("R6 first beat fill", got_val[42], expf(e, 3, 0));
        rsp_valid = 1'b1;
        rsp_tag   = t;
        rsp_beat  = 1'b1;
        rsp_data  = beatd(e, 1);
        set_miss(e, 20, 2, 43);
        @(negedge clk);
        chk("R10 accepted with final beat", 64'(miss_ready), 64'd1);
        @(posedge clk);
        #1;
        rsp_valid  = 1'b0;
        miss_valid = 1'b0;
        idle(3);
        chk("R10 no extra request", 64'(req_n - r0), 64'd1);
        chk("R10 late load data", got_val[43], expf(e, 20, 2));
        miss(e, 0, 1, 44);
        idle(2);
        chk("R9 released then new request", 64'(req_n - r0), 64'd2);
        beat(tag_of(e), 0, e);
        idle(2);
        chk("R9 new entry fill", got_val[44], expf(e, 0, 1));
        beat(tag_of(e), 1, e);
        idle(2);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        clear_got();
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_merge();
        t_capacity();
        t_slots();
        t_late_merge();
        finish_run();
    end

endmodule